// File: doc/BRIEF.md
# Configurable UART Serial Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single transmit line. A line-control word, made up of several separate input pins, sets the frame shape. It chooses a character length of 5 to 8 bits and a stop-bit length. It also enables or disables parity and chooses the parity type: odd, even, forced mark or forced space. A break override drives the line low for as long as it is held. Characters arrive with a valid/ready handshake. Bit timing comes from an external tick at sixteen times the baud rate.

Each frame has one low start bit, then the data bits with the least significant bit first, then an optional parity bit, then the stop time at logic 1. The frame settings and the character are captured when the character is accepted, so the host may change the line-control inputs while a frame is on the wire. Break has priority over everything else. It abandons any frame in progress, and the next accepted character starts a complete new frame once break is released.

Top module: `uart_tx_frame`

## Requirements
- R1: After reset the line is at logic 1, `busy` is 0 and `in_ready` is 1. Whenever `busy` is 0 and break is clear, `tx_out` is 1.
- R2: The length field `cfg_len` selects the data bit count: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. A frame is one logic-0 start bit followed by the low `cfg_len`-selected bits of `in_data`, least significant bit first.
- R3: With `cfg_par_en` = 0, no parity slot is sent, and the stop time follows the last data bit directly.
- R4: With `cfg_par_en` = 1 and `cfg_par_force` = 0, one parity slot follows the data. With `cfg_par_type` = 0 the data bits plus parity hold an odd number of ones. With `cfg_par_type` = 1 they hold an even number.
- R5: With `cfg_par_en` = 1 and `cfg_par_force` = 1, the parity slot is 1 when `cfg_par_type` = 0 and 0 when `cfg_par_type` = 1, whatever the data.
- R6: The stop time at logic 1 lasts 16 ticks when `cfg_stop_long` = 0. When `cfg_stop_long` = 1 it lasts 24 ticks for 5-bit characters and 32 ticks for 6, 7 or 8-bit characters.
- R7: Every start, data and parity slot lasts exactly 16 ticks of `tick_16x`. Slots advance only on cycles where `tick_16x` is high.
- R8: While `cfg_break` is 1, `tx_out` is 0 on every cycle and `in_ready` is 0. One cycle after break is raised, `busy` is 0.
- R9: A break raised during a frame abandons that frame. When break is cleared, the line is 1 again, and the next character is sent as a complete, correct frame.
- R10: The frame settings and the character are captured in the cycle of the handshake. Changes to the `cfg_*` inputs other than `cfg_break` have no effect on a frame already started.
- R11: A character is accepted on a cycle where both `in_valid` and `in_ready` are 1. `in_ready` is 1 only when the block is idle and break is clear. `busy` is 1 from the cycle after acceptance until the stop time ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_16x | input | 1 | One-cycle pulse at 16 times the baud rate |
| cfg_len | input | 2 | Character length code (00=5 through 11=8 bits) |
| cfg_stop_long | input | 1 | 0: one stop bit; 1: 1.5 (5-bit) or 2 stop bits |
| cfg_par_en | input | 1 | Parity slot enable |
| cfg_par_type | input | 1 | Parity type: odd/even, or mark/space when forced |
| cfg_par_force | input | 1 | Forces the parity slot to a constant |
| cfg_break | input | 1 | Holds the line low and aborts any frame |
| in_valid | input | 1 | Character available |
| in_data | input | 8 | Character, bit 0 sent first |
| in_ready | output | 1 | Block can accept a character |
| tx_out | output | 1 | Serial line |
| busy | output | 1 | A frame is in progress |

## Verification
Errors inside the block show up on the line within one frame. If the slot counter or the stop limit is wrong, the distance from a start edge to the fall of `busy` differs from the tick count the settings predict, so every frame is timed to the tick. If the bit index, the latched character or the parity is wrong, a slot carries the wrong level; each slot is sampled on all of its ticks. A broken break path shows up within one cycle: the line stays high, or `busy` stays up, or the frame after the release comes out short.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int CHAR_MAX = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       stop_long;
    logic       par_en;
    logic       par_type;
    logic       par_force;
  } frame_cfg_t;

  // number of data bits for a length code
  function automatic logic [3:0] char_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // mask keeping only the data bits of a character
  function automatic logic [CHAR_MAX-1:0] char_mask(input logic [1:0] len);
    return {CHAR_MAX{1'b1}} >> (2'd3 - len);
  endfunction

  // value carried by the parity slot
  function automatic logic parity_slot(input logic [CHAR_MAX-1:0] data,
                                       input frame_cfg_t cfg);
    logic [CHAR_MAX-1:0] used;
    used = data & char_mask(cfg.len);
    if (cfg.par_force) return ~cfg.par_type;
    if (cfg.par_type)  return ^used;
    return ~(^used);
  endfunction

  // stop time in ticks
  function automatic int stop_ticks(input frame_cfg_t cfg, input int tpb);
    if (!cfg.stop_long)   return tpb;
    if (cfg.len == 2'b00) return tpb + tpb / 2;
    return 2 * tpb;
  endfunction

endpackage

// File: rtl/uart_tx_cfg.sv
module uart_tx_cfg
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int CNT_W         = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CHAR_MAX-1:0] in_data,
  input  frame_cfg_t          cfg_in,
  output logic [CHAR_MAX-1:0] lat_data,
  output frame_cfg_t          lat_cfg,
  output logic [3:0]          nbits,
  output logic                par_bit,
  output logic [CNT_W-1:0]    stop_lim
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_data <= '0;
      lat_cfg  <= '0;
    end else if (load) begin
      lat_data <= in_data;
      lat_cfg  <= cfg_in;
    end
  end

  always_comb begin
    nbits    = char_bits(lat_cfg.len);
    par_bit  = parity_slot(lat_data, lat_cfg);
    stop_lim = CNT_W'(stop_ticks(lat_cfg, TICKS_PER_BIT));
  end

endmodule

// File: rtl/uart_tx_timer.sv
module uart_tx_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             slot_end
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last     = limit - CNT_W'(1);
  assign slot_end = tick && !clear && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clear)    cnt <= '0;
    else if (slot_end) cnt <= '0;
    else if (tick)     cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       brk,
  input  logic       slot_end,
  input  logic [3:0] nbits,
  input  logic       par_en,
  output tx_state_e  state,
  output logic [2:0] idx
);

  tx_state_e  state_nx;
  logic [2:0] idx_nx;
  logic       last_bit;

  assign last_bit = ({1'b0, idx} == nbits - 4'd1);

  always_comb begin
    state_nx = state;
    idx_nx   = idx;
    if (state != ST_IDLE && brk) begin
      state_nx = ST_IDLE;
      idx_nx   = '0;
    end else begin
      case (state)
        ST_IDLE:  if (load) begin
                    state_nx = ST_START;
                    idx_nx   = '0;
                  end
        ST_START: if (slot_end) state_nx = ST_DATA;
        ST_DATA:  if (slot_end) begin
                    if (last_bit) state_nx = par_en ? ST_PAR : ST_STOP;
                    else          idx_nx   = idx + 3'd1;
                  end
        ST_PAR:   if (slot_end) state_nx = ST_STOP;
        ST_STOP:  if (slot_end) state_nx = ST_IDLE;
        default:  state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= state_nx;
      idx   <= idx_nx;
    end
  end

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_16x,
  input  logic [1:0] cfg_len,
  input  logic       cfg_stop_long,
  input  logic       cfg_par_en,
  input  logic       cfg_par_type,
  input  logic       cfg_par_force,
  input  logic       cfg_break,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       tx_out,
  output logic       busy
);

  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1);

  frame_cfg_t          cfg_word;
  frame_cfg_t          lat_cfg;
  logic [CHAR_MAX-1:0] lat_data;
  logic [3:0]          nbits;
  logic                par_bit;
  logic [CNT_W-1:0]    stop_lim;
  logic [CNT_W-1:0]    slot_lim;
  logic                slot_end;
  logic                load;
  logic                in_stop;
  logic                line_bit;
  tx_state_e           state;
  logic [2:0]          idx;

  assign cfg_word = '{len: cfg_len, stop_long: cfg_stop_long, par_en: cfg_par_en,
                      par_type: cfg_par_type, par_force: cfg_par_force};

  assign in_ready = (state == ST_IDLE) && !cfg_break;
  assign load     = in_valid && in_ready;
  assign busy     = (state != ST_IDLE);
  assign in_stop  = (state == ST_STOP);
  assign slot_lim = in_stop ? stop_lim : CNT_W'(TICKS_PER_BIT);

  uart_tx_cfg #(.TICKS_PER_BIT(TICKS_PER_BIT), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load), .in_data(in_data), .cfg_in(cfg_word),
    .lat_data(lat_data), .lat_cfg(lat_cfg), .nbits(nbits), .par_bit(par_bit),
    .stop_lim(stop_lim)
  );

  uart_tx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(!busy), .tick(tick_16x), .limit(slot_lim),
    .slot_end(slot_end)
  );

  uart_tx_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .load(load), .brk(cfg_break), .slot_end(slot_end),
    .nbits(nbits), .par_en(lat_cfg.par_en), .state(state), .idx(idx)
  );

  always_comb begin
    case (state)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = lat_data[idx];
      ST_PAR:   line_bit = par_bit;
      default:  line_bit = 1'b1;
    endcase
  end

  assign tx_out = !cfg_break && line_bit;

endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int CNT_W         = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_16x,
  input logic             cfg_break,
  input logic             in_valid,
  input logic             in_ready,
  input logic             tx_out,
  input logic             busy,
  input logic             slot_end,
  input logic             in_stop,
  input logic [CNT_W-1:0] stop_lim,
  input frame_cfg_t       lat_cfg
);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_break) |-> tx_out);

  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  // R8
  break_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_break |=> !busy);

  // R7
  slot_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> tick_16x);

  // R6
  half_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && stop_lim == CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2)) |-> (lat_cfg.len == 2'b00));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(lat_cfg));

endmodule

bind uart_tx_frame uart_tx_chk #(.TICKS_PER_BIT(TICKS_PER_BIT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .cfg_break(cfg_break),
  .in_valid(in_valid), .in_ready(in_ready), .tx_out(tx_out), .busy(busy),
  .slot_end(slot_end), .in_stop(in_stop), .stop_lim(stop_lim), .lat_cfg(lat_cfg)
);

// File: tb/tb_uart_tx_frame.sv
`timescale 1ns/1ps
module tb_uart_tx_frame;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_16x = 1'b0;
  logic [1:0] cfg_len = 2'b00;
  logic       cfg_stop_long = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_type = 1'b0;
  logic       cfg_par_force = 1'b0;
  logic       cfg_break = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       tx_out;
  logic       busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic samp [0:255];

  uart_tx_frame dut (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .cfg_len(cfg_len),
    .cfg_stop_long(cfg_stop_long), .cfg_par_en(cfg_par_en), .cfg_par_type(cfg_par_type),
    .cfg_par_force(cfg_par_force), .cfg_break(cfg_break), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .tx_out(tx_out), .busy(busy)
  );

  always #4 clk = ~clk;

  // tick every second cycle, changed away from the active edge
  always @(negedge clk) tick_16x <= ~tick_16x;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_ticks(input logic [1:0] len, input bit sl, input bit pe);
    int n = int'(len) + 5;
    int st = !sl ? 16 : (len == 2'b00 ? 24 : 32);
    return 16 * (1 + n + (pe ? 1 : 0)) + st;
  endfunction

  function automatic bit exp_par(input logic [7:0] d, input logic [1:0] len,
                                 input bit ty, input bit fo);
    int ones = 0;
    for (int i = 0; i < int'(len) + 5; i++) if (d[i]) ones++;
    if (fo) return !ty;
    if (ty) return (ones % 2) == 1;
    return (ones % 2) == 0;
  endfunction

  function automatic bit exp_slot(input int s, input logic [7:0] d, input logic [1:0] len,
                                  input bit pe, input bit ty, input bit fo);
    int n = int'(len) + 5;
    if (s == 0) return 1'b0;
    if (s <= n) return d[s-1];
    if (pe && s == n + 1) return exp_par(d, len, ty, fo);
    return 1'b1;
  endfunction

  task automatic run_frame(input logic [7:0] d, input logic [1:0] len, input bit sl,
                           input bit pe, input bit ty, input bit fo, input bit scramble,
                           input string tag);
    int t = 0;
    int bad_at = -1;
    int n_slots;
    int et;
    @(negedge clk);
    in_data = d; cfg_len = len; cfg_stop_long = sl;
    cfg_par_en = pe; cfg_par_type = ty; cfg_par_force = fo;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (scramble) begin
      in_data = 8'($urandom); cfg_len = 2'($urandom);
      cfg_stop_long = 1'($urandom); cfg_par_en = 1'($urandom);
      cfg_par_type = 1'($urandom); cfg_par_force = 1'($urandom);
    end
    while (busy) begin
      if (tick_16x && t < 256) begin
        samp[t] = tx_out;
        t++;
      end
      @(negedge clk);
    end
    et = exp_ticks(len, sl, pe);
    check(t == et, {tag, " R6 R7 frame length in ticks"}, t, et);
    n_slots = 1 + int'(len) + 5 + (pe ? 1 : 0);
    for (int i = 0; i < t; i++) begin
      bit e = (i / 16 < n_slots) ? exp_slot(i / 16, d, len, pe, ty, fo) : 1'b1;
      if (samp[i] !== e && bad_at < 0) bad_at = i;
    end
    check(bad_at < 0, {tag, " R2 line level per tick (first bad tick as actual)"},
          bad_at, -1);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tx_out === 1'b1, "R1 idle line", int'(tx_out), 1);
    check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    check(in_ready === 1'b1 || !rst_n, "R1 ready during reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R1 ready after reset", int'(in_ready), 1);
    check(tx_out === 1'b1, "R1 line after reset", int'(tx_out), 1);

    // directed corners
    run_frame(8'hA5, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 no parity 8b");
    run_frame(8'h13, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 5b half stop");
    run_frame(8'hFF, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4 odd 8b two stop");
    run_frame(8'h00, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 odd zeros");
    run_frame(8'h00, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R4 even zeros");
    run_frame(8'h7F, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4 even 7b");
    run_frame(8'h00, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R5 forced mark");
    run_frame(8'hFF, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R5 forced space");
    run_frame(8'hE0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R10 upper bits masked");

    // R8 R9 break in the middle of a frame
    @(negedge clk);
    in_data = 8'h55; cfg_len = 2'b11; cfg_par_en = 1'b1; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (70) @(negedge clk);
    cfg_break = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R8 busy drops under break", int'(busy), 0);
    check(in_ready === 1'b0, "R8 ready low under break", int'(in_ready), 0);
    for (int i = 0; i < 60; i++) begin
      if (i % 10 == 0) check(tx_out === 1'b0, "R8 line held low", int'(tx_out), 0);
      if (i == 30) begin in_valid = 1'b1; in_data = 8'h3C; end
      @(negedge clk);
    end
    check(busy === 1'b0, "R8 no frame accepted during break", int'(busy), 0);
    in_valid = 1'b0;
    cfg_break = 1'b0;
    @(negedge clk);
    check(tx_out === 1'b1, "R9 line idle after release", int'(tx_out), 1);
    check(in_ready === 1'b1, "R9 ready after release", int'(in_ready), 1);
    run_frame(8'hC3, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 clean frame after break");

    // constrained random frames
    for (int k = 0; k < 100; k++) begin
      run_frame(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom % 2), "R10 random");
    end

    done = 1'b1;
    summary();
  end

endmodule